// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block buffers received serial bytes for a 16550-style UART. The receiver hands it one byte, or one break event, per strobe; the host side pops bytes by reading the data register and clears sticky error flags by reading the line status register. A FIFO control byte turns the buffer on or off, flushes it and selects the receive trigger level. With the buffer off, a single holding register stands in for it.

The block keeps the data-ready, overrun and break flags. It also keeps a character-timeout flag. The flag rises when stored bytes have gone unread for four character times. The character time arrives as a cycle count that the line-settings logic computes. Serialisation and bus decoding happen elsewhere.

Top module: `uart_rx_fifo`

## Requirements
- R1: Control bits 7:6 choose the trigger level: code 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. With the buffer on, `level_o` is high when the fill count is at least that level. With the buffer off, `level_o` follows data-ready.
- R2: A control write keeps only bits 7, 6, 3 and 0 (mask 0xC9), and `fcr_o` shows the kept value one cycle later. Bit 0 enables the buffer.
- R3: A control write that changes bit 0 flushes the receive buffer and clears the break and timeout flags. It also pulses `tx_flush_o` high for one cycle. Writing bit 2 set also pulses `tx_flush_o`.
- R4: A control write whose value equals `fcr_o` changes nothing.
- R5: A byte that arrives while all DEPTH entries are full is dropped and sets overrun. The stored bytes and the fill count stay as they were.
- R6: A break event stores a 0x00 byte and sets both the break flag and data-ready.
- R7: A data read pops the oldest byte, which is shown on `rd_data_o` before the edge. A pop that empties the buffer clears data-ready and break. Every data read clears the timeout flag.
- R8: Each arriving byte, and each pop that leaves data behind, restarts a countdown of 4 x `char_time_i` cycles. When it expires, the timeout flag is set, but only if the buffer holds data.
- R9: A line status read clears the break and overrun flags.
- R10: With the buffer off, one holding register takes each byte. A byte that arrives while data-ready is still set raises overrun and replaces the held byte. A data read clears data-ready.
- R11: A control write with bit 1 set, whose value differs from `fcr_o`, empties the receive buffer, clears the timeout flag and stops the countdown.
- R12: A data read from an empty buffer returns 0x00 and leaves the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fcr_wr_i | input | 1 | Control byte write strobe |
| fcr_data_i | input | 8 | Control byte value |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | DW | Received byte |
| rx_break_i | input | 1 | Break event strobe |
| rd_i | input | 1 | Data register read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| char_time_i | input | CT_W | One character time in cycles |
| rd_data_o | output | DW | Byte returned by a data read |
| fcr_o | output | 8 | Kept control bits |
| count_o | output | AW+1 | Receive fill count |
| data_ready_o | output | 1 | Data-ready flag |
| overrun_o | output | 1 | Overrun flag |
| break_o | output | 1 | Break flag |
| timeout_o | output | 1 | Character-timeout flag |
| level_o | output | 1 | Trigger level reached |
| tx_flush_o | output | 1 | One-cycle transmit flush request |

## Verification
The assertions check several rules on every cycle:
- the fill count never exceeds the depth;
- a byte that arrives while full raises overrun and leaves the count unchanged;
- a break raises both flags;
- any data read drops the timeout flag;
- the timeout flag never stands over an empty buffer;
- a line status read clears the sticky error flags;
- writes of an equal control value change nothing;
- flushes caused by the enable bit or the reset bit empty the buffer.

Other behaviour needs the bench's scenarios. These are the exact timeout latency, the restart of the countdown, the byte order and contents across a full buffer and an overrun, the trigger decode for every level, and the holding-register mode.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  localparam logic [7:0] FCR_KEEP = 8'hC9;
  localparam int FCR_EN  = 0;
  localparam int FCR_RXR = 1;
  localparam int FCR_TXR = 2;

  function automatic int trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxf_ctrl.sv
module uart_rxf_ctrl
  import uart_rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic [7:0] fcr_o,
  output logic       rx_clr_o,
  output logic       tx_clr_o
);
  logic [7:0] fcr_q;
  logic       change;

  // equal value is a no-op, enable flip forces both flushes
  assign change   = wr_i && (data_i != fcr_q);
  assign rx_clr_o = change && (data_i[FCR_RXR] || (data_i[FCR_EN] ^ fcr_q[FCR_EN]));
  assign tx_clr_o = change && (data_i[FCR_TXR] || (data_i[FCR_EN] ^ fcr_q[FCR_EN]));
  assign fcr_o    = fcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fcr_q <= '0;
    else if (change) fcr_q <= data_i & FCR_KEEP;
  end
endmodule

// File: rtl/uart_rxf_store.sv
module uart_rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [AW:0]   count_o,
  output logic          full_o,
  output logic          wr_ok_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          rd_ok;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign wr_ok_o = push_i && !full_o;
  assign rd_ok   = pop_i && (cnt_q != '0);
  assign dout_o  = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok_o && !clr_i) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_ok_o) wp_q <= wp_q + 1'b1;
      if (rd_ok)   rp_q <= rp_q + 1'b1;
      case ({wr_ok_o, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxf_timer.sv
module uart_rxf_timer #(
  parameter int CT_W = 16,
  localparam int TW  = CT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [CT_W-1:0] char_time_i,
  input  logic            nonempty_i,
  input  logic            ack_i,
  output logic            timeout_o
);
  logic [TW-1:0] cnt_q;
  logic          expire;
  logic          to_q;

  assign expire    = (cnt_q == TW'(1)) && !load_i;
  assign timeout_o = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= {char_time_i, 2'b00};
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  to_q <= 1'b0;
    else if (clr_i || ack_i)      to_q <= 1'b0;
    else if (expire && nonempty_i) to_q <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CT_W  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fcr_wr_i,
  input  logic [7:0]      fcr_data_i,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic            rx_break_i,
  input  logic            rd_i,
  input  logic            lsr_rd_i,
  input  logic [CT_W-1:0] char_time_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [7:0]      fcr_o,
  output logic [AW:0]     count_o,
  output logic            data_ready_o,
  output logic            overrun_o,
  output logic            break_o,
  output logic            timeout_o,
  output logic            level_o,
  output logic            tx_flush_o
);
  logic          rx_clr, tx_clr, fifo_en, rx_any;
  logic          f_push, f_pop, f_full, f_wr_ok, pop_empties, tmr_load;
  logic [DW-1:0] f_dout, rx_byte, hold_q;
  logic [AW:0]   f_cnt;
  logic          hold_dr_q, ovr_q, brk_q, txf_q;
  logic          h_rx, ovr_set;

  uart_rxf_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i(fcr_wr_i), .data_i(fcr_data_i),
    .fcr_o, .rx_clr_o(rx_clr), .tx_clr_o(tx_clr)
  );

  assign fifo_en = fcr_o[FCR_EN];
  assign rx_any  = (rx_valid_i || rx_break_i) && !rx_clr;
  assign rx_byte = rx_break_i ? '0 : rx_data_i;
  assign f_push  = fifo_en && rx_any;
  assign f_pop   = fifo_en && rd_i && !rx_clr;
  assign h_rx    = !fifo_en && rx_any;

  uart_rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(f_push), .din_i(rx_byte),
    .pop_i(f_pop), .dout_o(f_dout), .count_o(f_cnt), .full_o(f_full),
    .wr_ok_o(f_wr_ok)
  );

  assign pop_empties = f_pop && (f_cnt == (AW+1)'(1)) && !f_wr_ok;
  assign tmr_load    = f_push || (f_pop && (f_cnt != '0) && !pop_empties);

  uart_rxf_timer #(.CT_W(CT_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(rx_clr), .load_i(tmr_load),
    .char_time_i, .nonempty_i(f_cnt != '0), .ack_i(rd_i),
    .timeout_o
  );

  assign ovr_set = (f_push && f_full) || (h_rx && hold_dr_q && !rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0; hold_dr_q <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0; txf_q <= 1'b0;
    end else begin
      txf_q <= tx_clr;
      if (h_rx) hold_q <= rx_byte;
      if (h_rx)                     hold_dr_q <= 1'b1;
      else if (rd_i || rx_clr)      hold_dr_q <= 1'b0;
      if (ovr_set)                  ovr_q <= 1'b1;
      else if (lsr_rd_i)            ovr_q <= 1'b0;
      if (rx_any && rx_break_i)     brk_q <= 1'b1;
      else if (lsr_rd_i || rx_clr || pop_empties || (!fifo_en && rd_i)) brk_q <= 1'b0;
    end
  end

  assign count_o      = f_cnt;
  assign rd_data_o    = fifo_en ? ((f_cnt != '0) ? f_dout : '0) : hold_q;
  assign data_ready_o = fifo_en ? (f_cnt != '0) : hold_dr_q;
  assign level_o      = fifo_en ? (int'(f_cnt) >= trig_level(fcr_o[7:6])) : hold_dr_q;
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;
  assign tx_flush_o   = txf_q;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fcr_wr_i,
  input logic [7:0]    fcr_data_i,
  input logic          rx_valid_i,
  input logic          rx_break_i,
  input logic          rd_i,
  input logic          lsr_rd_i,
  input logic [7:0]    fcr_o,
  input logic [CW-1:0] count_o,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          break_o,
  input logic          timeout_o
);
  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH);

  p_full_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[0] && int'(count_o) == DEPTH && (rx_valid_i || rx_break_i) && !rd_i && !fcr_wr_i)
    |=> (overrun_o && int'(count_o) == DEPTH));

  p_break_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[0] && rx_break_i && !fcr_wr_i && !rd_i) |=> (break_o && data_ready_o));

  p_read_clears_to_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);

  p_to_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (count_o != '0));

  p_lsr_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rx_valid_i && !rx_break_i) |=> (!overrun_o && !break_o));

  p_same_fcr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_wr_i && fcr_data_i == fcr_o && !rx_valid_i && !rx_break_i && !rd_i)
    |=> ($stable(count_o) && $stable(fcr_o)));

  p_enable_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_wr_i && fcr_data_i[0] != fcr_o[0]) |=> (count_o == '0 && !timeout_o && !break_o));

  p_rx_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_wr_i && fcr_data_i != fcr_o && fcr_data_i[1]) |=> (count_o == '0 && !timeout_o));

  p_fcr_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o & 8'h36) == 8'h00);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .CW(AW+1)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fcr_wr_i(fcr_wr_i), .fcr_data_i(fcr_data_i),
  .rx_valid_i(rx_valid_i), .rx_break_i(rx_break_i), .rd_i(rd_i), .lsr_rd_i(lsr_rd_i),
  .fcr_o(fcr_o), .count_o(count_o), .data_ready_o(data_ready_o),
  .overrun_o(overrun_o), .break_o(break_o), .timeout_o(timeout_o)
);

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int CT_W  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fcr_wr = 1'b0;
  logic [7:0]      fcr_data = '0;
  logic            rx_valid = 1'b0;
  logic [DW-1:0]   rx_data = '0;
  logic            rx_break = 1'b0;
  logic            rd = 1'b0;
  logic            lsr_rd = 1'b0;
  logic [CT_W-1:0] char_time = 16'd3;
  logic [DW-1:0]   rd_data;
  logic [7:0]      fcr;
  logic [4:0]      count;
  logic            dr, ovr, brk, tmo, lvl, txf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(DW), .CT_W(CT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fcr_wr_i(fcr_wr), .fcr_data_i(fcr_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .rd_i(rd), .lsr_rd_i(lsr_rd), .char_time_i(char_time),
    .rd_data_o(rd_data), .fcr_o(fcr), .count_o(count), .data_ready_o(dr),
    .overrun_o(ovr), .break_o(brk), .timeout_o(tmo), .level_o(lvl),
    .tx_flush_o(txf)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    fcr_wr = 0; rx_valid = 0; rx_break = 0; rd = 0; lsr_rd = 0;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_wr = 1; fcr_data = v; tick();
  endtask

  task automatic push(input logic [7:0] v);
    rx_valid = 1; rx_data = v; tick();
  endtask

  task automatic pop();
    rd = 1; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R2 reset fcr", fcr, 0);
    chk("R7 reset data_ready", dr, 0);
    chk("R8 reset timeout", tmo, 0);
    chk("R12 reset count", count, 0);

    // R12: enable, read empty
    wr_fcr(8'h01);
    chk("R3 enable flush pulse", txf, 1);
    chk("R12 empty read data", rd_data, 0);
    pop();
    chk("R12 empty read count", count, 0);

    // R1/R5/R9/R7 sweep over trigger codes
    for (int code = 0; code < 4; code++) begin
      int lv;
      lv = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      wr_fcr({code[1:0], 6'b001011});
      chk("R2 kept bits", fcr, {code[1:0], 6'b001001});
      chk("R11 flushed", count, 0);
      chk("R1 level empty", lvl, 0);
      for (int i = 1; i <= DEPTH; i++) begin
        push(8'(code * 16 + i));
        chk("R1 level", lvl, int'(i >= lv));
      end
      chk("R5 no overrun yet", ovr, 0);
      push(8'hEE);
      chk("R5 overrun set", ovr, 1);
      chk("R5 count held", count, DEPTH);
      lsr_rd = 1; tick();
      chk("R9 overrun cleared", ovr, 0);
      for (int i = 1; i <= DEPTH; i++) begin
        chk("R5 order preserved", rd_data, code * 16 + i);
        pop();
      end
      chk("R7 empty clears ready", dr, 0);
      chk("R7 count zero", count, 0);
    end

    // R4: equal write keeps contents; R11 reset
    wr_fcr(8'hC1);
    push(8'h11); push(8'h12); push(8'h13);
    wr_fcr(8'hC1);
    chk("R4 equal write no effect", count, 3);
    chk("R4 fcr unchanged", fcr, 8'hC1);
    wr_fcr(8'hC3);
    chk("R11 rx reset", count, 0);

    // R8 timeout timing, char_time=3 -> 12 cycles
    push(8'h21);
    idle(11);
    chk("R8 not yet expired", tmo, 0);
    idle(1);
    chk("R8 expired", tmo, 1);
    push(8'h22);
    chk("R8 still set after push", tmo, 1);
    pop();
    chk("R7 read clears timeout", tmo, 0);
    idle(11);
    chk("R8 restart after pop", tmo, 0);
    idle(1);
    chk("R8 expired after pop", tmo, 1);
    pop();
    chk("R7 timeout clear on last pop", tmo, 0);
    idle(20);
    chk("R8 empty never times out", tmo, 0);
    push(8'h23);
    idle(5);
    wr_fcr(8'hC1);
    wr_fcr(8'hC3);
    idle(20);
    chk("R11 timer stopped", tmo, 0);
    chk("R11 count cleared", count, 0);

    // R6 break
    rx_break = 1; tick();
    chk("R6 break flag", brk, 1);
    chk("R6 data ready", dr, 1);
    chk("R6 zero byte", rd_data, 0);
    chk("R6 count", count, 1);
    pop();
    chk("R7 break clears on empty", brk, 0);
    rx_break = 1; tick();
    lsr_rd = 1; tick();
    chk("R9 break cleared", brk, 0);
    chk("R9 data ready kept", dr, 1);
    pop();

    // R3 enable flip flushes
    push(8'h31); push(8'h32);
    wr_fcr(8'h00);
    chk("R3 flushed on disable", count, 0);
    chk("R3 tx flush pulse", txf, 1);
    tick();
    chk("R3 tx flush one cycle", txf, 0);
    wr_fcr(8'h04);
    chk("R3 tx flush bit2", txf, 1);

    // R10 holding register
    push(8'h5A);
    chk("R10 ready", dr, 1);
    chk("R10 data", rd_data, 8'h5A);
    chk("R1 level follows ready", lvl, 1);
    push(8'h66);
    chk("R10 overrun", ovr, 1);
    chk("R10 replaced", rd_data, 8'h66);
    pop();
    chk("R10 read clears ready", dr, 0);
    lsr_rd = 1; tick();
    chk("R9 hold overrun cleared", ovr, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule